// File: doc/BRIEF.md
# Maskable Interrupt Flag and Status Unit

This block collects three event sources of a real-time clock: a periodic tick, an alarm match and the end of a time update. Each event raises a sticky flag. A host reads those flags through an event-status byte. A control byte holds a per-source enable. A summary flag and the active-low interrupt request are raised whenever a flag and its enable are both set. A single read of the status byte returns the flags and clears them all in the same access, and this also releases the request.

The control byte also holds an update-inhibit bit. Setting that bit forces the update-source enable to zero. The control byte also carries four mode bits that neighbouring blocks decode, and this block only stores them. A third read-only byte reports whether the backup supply is good. Host accesses use an address, a one-cycle read or write strobe and registered read data. The read data appears in the cycle after the strobe.

Top module: `irq_status_unit`

## Requirements
- R1: A write to the control address (default 0x0B) stores the byte, and a read of that address returns it on `rd_data` one cycle after the strobe.
- R2: When a stored control byte has bit 7 (update inhibit) at 1, its bit 4 (update enable) is forced to 0, including when both bits are written as 1 in the same write.
- R3: `rst` clears control bits 6, 5, 4 and 3 and leaves bits 7, 2, 1 and 0 at their previous values.
- R4: In the status byte (default address 0x0C), bit 6 is the periodic flag, bit 5 is the alarm flag and bit 4 is the update flag. Bits 3 to 0 always read 0. An event on `evt_in` (bit 2 periodic, bit 1 alarm, bit 0 update) sets its flag whatever the state of its enable.
- R5: The enables are control bits 6 (periodic), 5 (alarm) and 4 (update). When a flag and its enable are both 1, status bit 7 is set and `irq_n` goes low in the cycle after the cause. This also holds when the enable is written after the flag was already set.
- R6: A read of the status byte returns the flags as they were before the read. It then clears all flags and status bit 7, and it releases the request (`irq_n` = 1, `irq_released` = 1).
- R7: An event that arrives in the same cycle as a status read is kept as a flag. If that event is enabled, the request is raised again.
- R8: A read of the integrity byte (default address 0x0D) returns `batt_ok` in bit 7 and 0 in bits 6 to 0.
- R9: Writes to the status address or the integrity address change neither the flags nor the control byte.
- R10: `rst` clears all flags and the summary bit, releases the request and zeroes `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 3 | Event pulses: bit 2 periodic, bit 1 alarm, bit 0 update ended |
| bus_addr | input | ADDR_W | Register address of the host access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| batt_ok | input | 1 | Backup supply good indication |
| rd_data | output | 8 | Registered read data |
| ctrl_q | output | 8 | Stored control byte, for neighbouring blocks |
| irq_n | output | 1 | Interrupt request, active low |
| irq_released | output | 1 | High when the request is released (open-drain off) |

## Verification
The bench builds the block with its default parameters: a 7-bit address and the three register addresses at 0x0B, 0x0C and 0x0D. With this 7-bit address the writes that miss the control register land on real neighbouring addresses (the status and integrity bytes). That lets the bench show that those writes leave the state untouched. The default three-source layout places every flag next to its enable bit. This makes reachable the late-enable case, the inhibit-forces-clear case and the case where an event coincides with a clearing read.

// File: rtl/irqsu_pkg.sv
package irqsu_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_SRC = 3;   // update, alarm, periodic
  localparam int SRC_LSB = 4;   // flag i and enable i both sit at bit SRC_LSB+i
  localparam int UPD_IDX = 0;   // update-ended source index
  localparam int INH_BIT = 7;   // update inhibit in the control byte
  localparam int SUM_BIT = 7;   // summary bit in the status byte
  localparam int VLD_BIT = 7;   // supply-good bit in the integrity byte
  localparam int CLR_LO  = 3;   // control bits cleared by reset
  localparam int CLR_HI  = 6;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/irqsu_ctrl.sv
module irqsu_ctrl
  import irqsu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_hit,
  input  byte_t              wdata,
  output byte_t              ctrl_q,
  output logic [NUM_SRC-1:0] en_nxt
);
  byte_t nxt;

  always_comb begin
    nxt = ctrl_q;
    if (wr_hit) nxt = wdata;
    if (nxt[INH_BIT]) nxt[SRC_LSB+UPD_IDX] = 1'b0;
  end

  // Reset touches only the enable and output-enable field; mode bits persist.
  always_ff @(posedge clk) begin
    if (rst) ctrl_q[CLR_HI:CLR_LO] <= '0;
    else     ctrl_q <= nxt;
  end

  assign en_nxt = rst ? '0 : nxt[SRC_LSB +: NUM_SRC];
endmodule

// File: rtl/irqsu_flags.sv
module irqsu_flags
  import irqsu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr,
  input  logic [NUM_SRC-1:0] en_nxt,
  output logic [NUM_SRC-1:0] flags_q,
  output logic               sum_q
);
  logic [NUM_SRC-1:0] flag_nxt;

  // A same-cycle event outranks the clearing read so it is never dropped.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    assign flag_nxt[i] = evt[i] | (flags_q[i] & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      sum_q   <= 1'b0;
    end else begin
      flags_q <= flag_nxt;
      sum_q   <= (sum_q & ~clr) | (|(flag_nxt & en_nxt));
    end
  end
endmodule

// File: rtl/irqsu_rdata.sv
module irqsu_rdata
  import irqsu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic               sel_ctrl,
  input  logic               sel_stat,
  input  logic               sel_integ,
  input  byte_t              ctrl_q,
  input  logic [NUM_SRC-1:0] flags_q,
  input  logic               sum_q,
  input  logic               batt_ok,
  output byte_t              rd_data
);
  byte_t stat_b, integ_b, mux_b;

  always_comb begin
    stat_b = '0;
    stat_b[SUM_BIT] = sum_q;
    stat_b[SRC_LSB +: NUM_SRC] = flags_q;
    integ_b = '0;
    integ_b[VLD_BIT] = batt_ok;
    mux_b = '0;
    if (sel_ctrl)  mux_b = ctrl_q;
    if (sel_stat)  mux_b = stat_b;
    if (sel_integ) mux_b = integ_b;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_data <= '0;
    else if (rd) rd_data <= mux_b;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irqsu_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int CTRL_ADDR  = 11,
  parameter int STAT_ADDR  = 12,
  parameter int INTEG_ADDR = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               batt_ok,
  output logic [DATA_W-1:0]  rd_data,
  output logic [DATA_W-1:0]  ctrl_q,
  output logic               irq_n,
  output logic               irq_released
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_INTEG = ADDR_W'(INTEG_ADDR);

  logic sel_ctrl, sel_stat, sel_integ, stat_clr, sum_q;
  logic [NUM_SRC-1:0] en_nxt, flags_q;

  assign sel_ctrl  = (bus_addr == A_CTRL);
  assign sel_stat  = (bus_addr == A_STAT);
  assign sel_integ = (bus_addr == A_INTEG);
  assign stat_clr  = bus_rd & sel_stat;

  irqsu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(bus_wr & sel_ctrl), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .en_nxt(en_nxt)
  );

  irqsu_flags u_flags (
    .clk(clk), .rst(rst), .evt(evt_in), .clr(stat_clr), .en_nxt(en_nxt),
    .flags_q(flags_q), .sum_q(sum_q)
  );

  irqsu_rdata u_rdata (
    .clk(clk), .rst(rst), .rd(bus_rd), .sel_ctrl(sel_ctrl), .sel_stat(sel_stat),
    .sel_integ(sel_integ), .ctrl_q(ctrl_q), .flags_q(flags_q), .sum_q(sum_q),
    .batt_ok(batt_ok), .rd_data(rd_data)
  );

  assign irq_n        = ~sum_q;
  assign irq_released = ~sum_q;
endmodule

// File: rtl/irqsu_chk.sv
module irqsu_chk
  import irqsu_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int STAT_ADDR  = 12,
  parameter int INTEG_ADDR = 13
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt_in,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  rd_data,
  input logic [DATA_W-1:0]  ctrl_q,
  input logic               irq_n
);
  logic st_rd, ig_rd;
  assign st_rd = bus_rd && (bus_addr == ADDR_W'(STAT_ADDR));
  assign ig_rd = bus_rd && (bus_addr == ADDR_W'(INTEG_ADDR));

  AST_INHIBIT_CLEARS_UPD_EN: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[INH_BIT] |-> !ctrl_q[SRC_LSB+UPD_IDX]); // R2

  AST_ENABLED_ALARM_RAISES: assert property (@(posedge clk) disable iff (rst)
    (evt_in[1] && ctrl_q[SRC_LSB+1] && !st_rd && !bus_wr) |=> !irq_n); // R5

  AST_STAT_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (st_rd && evt_in == '0) |=> irq_n); // R6

  AST_STAT_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(st_rd) |-> rd_data[3:0] == 4'h0); // R4

  AST_INTEG_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(ig_rd) |-> rd_data[6:0] == 7'h00); // R8

  AST_RESET_RELEASES: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irq_n); // R10
endmodule

bind irq_status_unit irqsu_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .INTEG_ADDR(INTEG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .evt_in(evt_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .rd_data(rd_data), .ctrl_q(ctrl_q), .irq_n(irq_n)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  localparam logic [6:0] A_B = 7'h0B, A_C = 7'h0C, A_D = 7'h0D;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] evt_in = '0;
  logic [6:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, batt_ok = 1'b1;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rd_data, ctrl_q;
  logic irq_n, irq_released;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_status_unit u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .batt_ok(batt_ok), .rd_data(rd_data),
    .ctrl_q(ctrl_q), .irq_n(irq_n), .irq_released(irq_released)
  );

  // {kind[2:0], payload[7:0], expected read byte[7:0], expected irq_n}
  // kind: 0 event, 1 write control, 2 read control, 3 read status, 4 read integrity
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {3'd1, 8'h00, 8'h00, 1'b1},  // R1 clear control
    {3'd3, 8'h00, 8'h00, 1'b1},  // R4 nothing pending
    {3'd0, 8'h02, 8'h00, 1'b1},  // R4 alarm, not enabled
    {3'd3, 8'h00, 8'h20, 1'b1},  // R4 flag visible for polling
    {3'd3, 8'h00, 8'h00, 1'b1},  // R6 cleared by previous read
    {3'd1, 8'h20, 8'h00, 1'b1},  // R1 enable alarm
    {3'd0, 8'h02, 8'h00, 1'b0},  // R5 enabled alarm raises request
    {3'd3, 8'h00, 8'hA0, 1'b1},  // R6 summary+alarm, released
    {3'd0, 8'h04, 8'h00, 1'b1},  // R4 periodic, not enabled
    {3'd1, 8'h60, 8'h00, 1'b0},  // R5 late enable raises request
    {3'd3, 8'h00, 8'hC0, 1'b1},  // R6
    {3'd1, 8'h90, 8'h00, 1'b1},  // R2 inhibit with update enable
    {3'd2, 8'h00, 8'h80, 1'b1},  // R2 update enable forced off
    {3'd0, 8'h01, 8'h00, 1'b1},  // R4 update event still flagged
    {3'd3, 8'h00, 8'h10, 1'b1},  // R4
    {3'd1, 8'h1F, 8'h00, 1'b1},  // R1
    {3'd2, 8'h00, 8'h1F, 1'b1},  // R1 readback
    {3'd0, 8'h07, 8'h00, 1'b0},  // R5 update enabled
    {3'd3, 8'h00, 8'hF0, 1'b1},  // R4 R6 all flags
    {3'd4, 8'h00, 8'h80, 1'b1}   // R8 supply good
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] kind, input logic [7:0] pl);
    case (kind)
      3'd0: evt_in = pl[2:0];
      3'd1: begin bus_wr = 1'b1; bus_addr = A_B; bus_wdata = pl; end
      3'd2: begin bus_rd = 1'b1; bus_addr = A_B; end
      3'd3: begin bus_rd = 1'b1; bus_addr = A_C; end
      default: begin bus_rd = 1'b1; bus_addr = A_D; end
    endcase
    @(negedge clk);
    evt_in = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
  endtask

  task automatic wr_at(input logic [6:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset irq_n", {7'b0, irq_n}, 8'h01);
    chk("R10 reset released", {7'b0, irq_released}, 8'h01);
    chk("R10 reset rd_data", rd_data, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][19:17], VEC[i][16:9]);
      if (VEC[i][19:17] >= 3'd2) chk($sformatf("vec%0d R1/R4/R6/R8 data", i), rd_data, VEC[i][8:1]);
      chk($sformatf("vec%0d R5/R6 irq_n", i), {7'b0, irq_n}, {7'b0, VEC[i][0]});
    end

    // R7: event in the same cycle as a clearing read is kept
    apply(3'd1, 8'h60);
    apply(3'd0, 8'h02);
    bus_rd = 1'b1; bus_addr = A_C; evt_in = 3'b100;
    @(negedge clk);
    bus_rd = 1'b0; evt_in = '0;
    chk("R6 read before clear", rd_data, 8'hA0);
    chk("R7 kept enabled event re-raises", {7'b0, irq_n}, 8'h00);
    apply(3'd3, 8'h00);
    chk("R7 kept periodic flag", rd_data, 8'hC0);

    // R9: writes to read-only addresses ignored
    apply(3'd0, 8'h01);
    wr_at(A_C, 8'h00);
    wr_at(A_D, 8'hFF);
    apply(3'd3, 8'h00);
    chk("R9 status write ignored", rd_data, 8'h10);
    apply(3'd2, 8'h00);
    chk("R9 control untouched", rd_data, 8'h60);

    // R8: supply bad
    batt_ok = 1'b0;
    apply(3'd4, 8'h00);
    chk("R8 supply bad", rd_data, 8'h00);
    batt_ok = 1'b1;

    // R2: inhibit and update enable written together
    apply(3'd1, 8'hFF);
    apply(3'd2, 8'h00);
    chk("R2 write FF", rd_data, 8'hEF);

    // R3 / R10: reset keeps mode bits, clears enables, flags and request
    apply(3'd0, 8'h02);
    chk("R5 alarm pending before reset", {7'b0, irq_n}, 8'h00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset releases request", {7'b0, irq_released}, 8'h01);
    apply(3'd2, 8'h00);
    chk("R3 control after reset", rd_data, 8'h87);
    apply(3'd3, 8'h00);
    chk("R10 flags cleared by reset", rd_data, 8'h00);

    finish_run();
  end
endmodule